// File: doc/BRIEF.md
# Stride-Configurable Partial-Sum Combiner

This block is the second adder stage behind a 6-row by 3-column processing-element matrix. It receives 18 partial sums per cycle, one for each pair of tile row and kernel row. A fixed row-wise adder net in front of it has already formed each of these by adding, across the three PEs of a row, the products that share a thread index. The block adds partial sums along the column direction into the outputs of a 3×3 convolution, at vertical stride 1 or stride 2. Input tiles move across the image width first and then drop down by six rows, which starts a new band.

A 3×3 window that starts in the last two rows of a band needs rows from the band below it. For those windows, two boundary values per tile position go into a circular delay line. Its length is loaded when a layer starts and equals the number of tile positions per band. A stored value comes back out when the tile at the same horizontal position in the next band arrives, and it is completed there. During the first band the delay line contents are treated as zero and the boundary outputs are not flagged. Each of the six output lanes carries its own valid bit.

A sequencer state machine has three states. `ST_IDLE` is the state after reset, and input is ignored in it. `ST_FIRST_BAND` covers the first band of a layer. `ST_LATER_BAND` covers every later band. Transitions: a `start` pulse moves any state to `ST_FIRST_BAND`. `ST_FIRST_BAND` moves to `ST_LATER_BAND` when it accepts the input at the last tile position of a band. `ST_LATER_BAND` stays where it is until the next `start`.

Top module: `psum_combiner`

## Requirements
- R1: After reset, `out_valid` is 0 and every lane of `out_sum` is 0. Until the first `start` pulse, inputs with `in_valid` high produce no valid output.
- R2: Partial sum n = 3*r + k (tile row r 0..5, kernel row k 0..2) arrives in bits [16n+15:16n] of `in_psum` as a signed value. One cycle after it is accepted, lane 2+i (i = 0..3) holds p(i,0) + p(i+1,1) + p(i+2,2).
- R3: For inputs accepted during the first band, lanes 0 and 1 are not flagged valid and read 0.
- R4: In later bands, lane 0 = p'(4,0) + p'(5,1) + p(0,2) and lane 1 = p'(5,0) + p(0,1) + p(1,2). Here p' is taken from the input accepted at the same tile position one band earlier.
- R5: The band length is `cfg_len` + 1 accepted inputs (1 to 16 with default parameters). After that many accepted inputs the next band begins, and the tile position wraps to 0.
- R6: With `cfg_stride2` = 1, `out_valid` is 6'b010100 in the first band and 6'b010101 in later bands. With stride 1 it is 6'b111100 in the first band and 6'b111111 in later bands (bit i = lane i).
- R7: A cycle with `in_valid` low produces `out_valid` = 0 and does not advance the tile position, so alignment with the delay line is kept.
- R8: `cfg_len` and `cfg_stride2` are captured only in the cycle where `start` is high. Changes to them at any other time have no effect.
- R9: Sums are exact 20-bit signed values over the whole 16-bit input range, including all inputs at +32767 or at −32768.
- R10: A `start` pulse in the middle of a layer restarts it: the next accepted input is tile position 0 of a first band. Input presented in the `start` cycle is ignored.
- R11: Every lane whose valid bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a layer and captures the configuration |
| cfg_len | input | 4 | Tile positions per band minus one |
| cfg_stride2 | input | 1 | 1 selects vertical stride 2, 0 selects stride 1 |
| in_valid | input | 1 | Partial sums on `in_psum` are valid |
| in_psum | input | 288 | 18 signed 16-bit partial sums, index 3*row + kernel row |
| out_valid | output | 6 | Per-lane valid flags |
| out_sum | output | 120 | Six signed 20-bit results, lane i in bits [20i+19:20i] |

## Verification
A pseudo-random ramp pattern, different at every tile position, band and index, is run at stride 1 over three bands. A swapped pairing of stored values with current values, or a delay length that is off by one, then shows up as a wrong sum. Stride 2 is run with the same pattern, so a mask error stands apart from an arithmetic error. Gap cycles, configuration changes in mid-layer and restarts in mid-layer each test the bookkeeping of tile positions separately from the arithmetic. Constant and alternating inputs at full scale, run with the shortest and the longest band lengths, exercise the sign extension and the wrap of the delay line.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
    localparam int TILE_ROWS = 6;
    localparam int KROWS     = 3;
    localparam int NUM_PSUM  = TILE_ROWS * KROWS;
    localparam int NUM_LANES = 6;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FIRST_BAND = 2'd1,
        ST_LATER_BAND = 2'd2
    } band_state_e;

    function automatic int pidx(int row, int krow);
        return row * KROWS + krow;
    endfunction
endpackage

// File: rtl/psc_sequencer.sv
`timescale 1ns/1ps
module psc_sequencer #(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         cfg_len,
    input  logic                      cfg_stride2,
    input  logic                      in_valid,
    output psc_pkg::band_state_e      state,
    output logic [ADDR_W-1:0]         col,
    output logic                      stride2_q,
    output logic                      accept
);
    import psc_pkg::*;

    band_state_e       state_n;
    logic [ADDR_W-1:0] len_q;
    logic              at_end;

    always_comb begin
        accept = in_valid && !start && (state != ST_IDLE);
        at_end = (col == len_q);
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:       if (start) state_n = ST_FIRST_BAND;
            ST_FIRST_BAND: begin
                if (start)                state_n = ST_FIRST_BAND;
                else if (accept && at_end) state_n = ST_LATER_BAND;
            end
            ST_LATER_BAND: if (start) state_n = ST_FIRST_BAND;
            default:       state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col       <= '0;
            len_q     <= '0;
            stride2_q <= 1'b0;
        end else if (start) begin
            col       <= '0;
            len_q     <= cfg_len;
            stride2_q <= cfg_stride2;
        end else if (accept) begin
            col <= at_end ? '0 : col + 1'b1;
        end
    end

    assert_col_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col <= len_q);

    assert_band_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_LATER_BAND) |-> $past(accept && at_end));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !start) |=> $stable(col));

    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(len_q) && $stable(stride2_q)));
endmodule

// File: rtl/psc_delay_line.sv
`timescale 1ns/1ps
module psc_delay_line #(
    parameter int WIDTH  = 40,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    always_comb rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
endmodule

// File: rtl/psc_combine.sv
`timescale 1ns/1ps
module psc_combine #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 20
) (
    input  logic [psc_pkg::NUM_PSUM*IN_W-1:0]   psum_flat,
    input  logic                                use_prev,
    input  logic signed [ACC_W-1:0]             prev_b4,
    input  logic signed [ACC_W-1:0]             prev_b5,
    output logic [psc_pkg::NUM_LANES*ACC_W-1:0] lane_flat,
    output logic signed [ACC_W-1:0]             keep_b4,
    output logic signed [ACC_W-1:0]             keep_b5
);
    import psc_pkg::*;

    logic signed [ACC_W-1:0] ext [NUM_PSUM];
    logic signed [ACC_W-1:0] b4_eff, b5_eff;

    for (genvar n = 0; n < NUM_PSUM; n++) begin : g_ext
        assign ext[n] = {{(ACC_W-IN_W){psum_flat[n*IN_W+IN_W-1]}}, psum_flat[n*IN_W +: IN_W]};
    end

    for (genvar i = 0; i < NUM_LANES - 2; i++) begin : g_inner
        assign lane_flat[(i+2)*ACC_W +: ACC_W] =
            ext[pidx(i, 0)] + ext[pidx(i+1, 1)] + ext[pidx(i+2, 2)];
    end

    always_comb begin
        b4_eff  = use_prev ? prev_b4 : '0;
        b5_eff  = use_prev ? prev_b5 : '0;
        lane_flat[0 +: ACC_W]     = b4_eff + ext[pidx(0, 2)];
        lane_flat[ACC_W +: ACC_W] = b5_eff + ext[pidx(0, 1)] + ext[pidx(1, 2)];
        keep_b4 = ext[pidx(4, 0)] + ext[pidx(5, 1)];
        keep_b5 = ext[pidx(5, 0)];
    end
endmodule

// File: rtl/psum_combiner.sv
`timescale 1ns/1ps
module psum_combiner #(
    parameter int IN_W   = 16,
    parameter int ACC_W  = 20,
    parameter int ADDR_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [ADDR_W-1:0]                   cfg_len,
    input  logic                                cfg_stride2,
    input  logic                                in_valid,
    input  logic [psc_pkg::NUM_PSUM*IN_W-1:0]   in_psum,
    output logic [psc_pkg::NUM_LANES-1:0]       out_valid,
    output logic [psc_pkg::NUM_LANES*ACC_W-1:0] out_sum
);
    import psc_pkg::*;

    band_state_e                 state;
    logic [ADDR_W-1:0]           col;
    logic                        stride2_q;
    logic                        accept;
    logic                        later;
    logic [2*ACC_W-1:0]          dl_rdata;
    logic [NUM_LANES*ACC_W-1:0]  lane_flat;
    logic signed [ACC_W-1:0]     keep_b4, keep_b5;
    logic [NUM_LANES-1:0]        mask_n;

    psc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_stride2(cfg_stride2), .in_valid(in_valid), .state(state),
        .col(col), .stride2_q(stride2_q), .accept(accept)
    );

    psc_delay_line #(.WIDTH(2*ACC_W), .ADDR_W(ADDR_W)) u_dly (
        .clk(clk), .we(accept), .addr(col),
        .wdata({keep_b5, keep_b4}), .rdata(dl_rdata)
    );

    psc_combine #(.IN_W(IN_W), .ACC_W(ACC_W)) u_cmb (
        .psum_flat(in_psum), .use_prev(later),
        .prev_b4(dl_rdata[ACC_W-1:0]), .prev_b5(dl_rdata[2*ACC_W-1:ACC_W]),
        .lane_flat(lane_flat), .keep_b4(keep_b4), .keep_b5(keep_b5)
    );

    always_comb begin
        later  = (state == ST_LATER_BAND);
        mask_n = stride2_q ? 6'b010100 : 6'b111100;
        if (later) mask_n = mask_n | (stride2_q ? 6'b000001 : 6'b000011);
        if (!accept) mask_n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_sum   <= '0;
        end else begin
            out_valid <= mask_n;
            for (int l = 0; l < NUM_LANES; l++)
                out_sum[l*ACC_W +: ACC_W] <= mask_n[l] ? lane_flat[l*ACC_W +: ACC_W] : '0;
        end
    end

    assert_out_follows_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> $past(accept));

    assert_boundary_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> $past(state == ST_LATER_BAND));

    assert_stride2_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stride2_q) |-> (out_valid[1] == 1'b0 && out_valid[3] == 1'b0 && out_valid[5] == 1'b0));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_zero_chk
        assert_idle_lane_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[l] |-> (out_sum[l*ACC_W +: ACC_W] == '0));
    end
endmodule

// File: tb/psum_combiner_test.sv
`timescale 1ns/1ps
module psum_combiner_test;
    localparam int IN_W = 16, ACC_W = 20, ADDR_W = 4, NP = 18, NL = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n, start, cfg_stride2, in_valid;
    logic [ADDR_W-1:0]    cfg_len;
    logic [NP*IN_W-1:0]   in_psum;
    logic [NL-1:0]        out_valid;
    logic [NL*ACC_W-1:0]  out_sum;

    psum_combiner uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_stride2(cfg_stride2), .in_valid(in_valid), .in_psum(in_psum),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int prevv [16][NP];
    int b_col, b_band, b_len;
    bit b_s2, b_active;

    function automatic int gen(int pat, int b, int c, int n);
        case (pat)
            1:       return 32767;
            2:       return -32768;
            3:       return (((b + c + n) % 2) == 0) ? 32767 : -32768;
            default: return ((b * 53 + c * 29 + n * 17 + 7) % 401) - 200;
        endcase
    endfunction

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, then check the registered result one edge later
    task automatic step(int pat, bit valid, string tag);
        int cur [NP];
        int e [NL];
        logic [NL-1:0] m;
        bit later, acc;
        for (int n = 0; n < NP; n++) begin
            cur[n] = gen(pat, b_band, b_col, n);
            in_psum[n*IN_W +: IN_W] = IN_W'(cur[n]);
        end
        in_valid = valid;
        acc   = valid && b_active;
        later = (b_band > 0);
        for (int i = 0; i < 4; i++)
            e[2+i] = cur[i*3] + cur[(i+1)*3+1] + cur[(i+2)*3+2];
        e[0] = (later ? prevv[b_col][12] + prevv[b_col][16] : 0) + cur[2];
        e[1] = (later ? prevv[b_col][15] : 0) + cur[1] + cur[5];
        m = b_s2 ? (later ? 6'b010101 : 6'b010100) : (later ? 6'b111111 : 6'b111100);
        if (!acc) m = '0;
        @(posedge clk);
        @(negedge clk);
        check_int({tag, " mask"}, int'(out_valid), int'(m));
        for (int l = 0; l < NL; l++)
            check_int($sformatf("%s lane%0d (R11 when masked)", tag, l),
                      int'($signed(out_sum[l*ACC_W +: ACC_W])), m[l] ? e[l] : 0);
        in_valid = 1'b0;
        if (acc) begin
            for (int n = 0; n < NP; n++) prevv[b_col][n] = cur[n];
            if (b_col == b_len - 1) begin b_col = 0; b_band++; end
            else b_col++;
        end
    endtask

    task automatic do_start(int len_code, bit s2);
        start = 1'b1; cfg_len = ADDR_W'(len_code); cfg_stride2 = s2; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        check_int("R10 start-cycle input ignored", int'(out_valid), 0);
        b_len = len_code + 1; b_s2 = s2; b_col = 0; b_band = 0; b_active = 1'b1;
    endtask

    task automatic test_reset;
        check_int("R1 reset out_valid", int'(out_valid), 0);
        check_int("R1 reset out_sum", int'(out_sum == '0), 1);
        b_active = 1'b0; b_s2 = 1'b0; b_band = 0; b_col = 0; b_len = 1;
        for (int k = 0; k < 3; k++) step(0, 1'b1, "R1 idle input");
    endtask

    task automatic test_stride1;
        do_start(3, 1'b0);
        for (int k = 0; k < 12; k++) step(0, 1'b1, "R2 R3 R4 R5 stride1");
    endtask

    task automatic test_stride2;
        do_start(2, 1'b1);
        for (int k = 0; k < 6; k++) step(0, 1'b1, "R6 stride2");
    endtask

    task automatic test_gaps;
        do_start(4, 1'b0);
        for (int k = 0; k < 15; k++) begin
            step(0, 1'b1, "R7 with gaps");
            if (k % 3 == 1) step(0, 1'b0, "R7 gap cycle");
        end
    endtask

    task automatic test_cfg_ignored;
        do_start(2, 1'b0);
        for (int k = 0; k < 9; k++) begin
            cfg_len = ADDR_W'(7 + k); cfg_stride2 = k[0];
            step(0, 1'b1, "R8 cfg change ignored");
        end
    endtask

    task automatic test_extremes;
        do_start(0, 1'b0);
        for (int k = 0; k < 3; k++) step(3, 1'b1, "R9 alternating full scale len1");
        for (int k = 0; k < 2; k++) step(1, 1'b1, "R9 all max");
        for (int k = 0; k < 2; k++) step(2, 1'b1, "R9 all min");
    endtask

    task automatic test_max_len;
        do_start(15, 1'b0);
        for (int k = 0; k < 34; k++) step(0, 1'b1, "R5 longest band");
    endtask

    task automatic test_restart;
        do_start(2, 1'b0);
        for (int k = 0; k < 5; k++) step(0, 1'b1, "R10 before restart");
        do_start(1, 1'b1);
        for (int k = 0; k < 4; k++) step(0, 1'b1, "R10 after restart");
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; cfg_len = '0; cfg_stride2 = 1'b0;
        in_valid = 1'b0; in_psum = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset;
        test_stride1;
        test_stride2;
        test_gaps;
        test_cfg_ignored;
        test_extremes;
        test_max_len;
        test_restart;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements act=timeout exp=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule